// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block owns a small pool of fixed-size packet pages for an Ethernet controller. It tracks which pages are in use, hands out the lowest free page on request, and keeps three queues of page numbers: transmit-pending, transmit-done and receive. Software drives it with a one-byte command whose top three bits select the operation. A separate packet-number register names the page that a release or enqueue command acts on.

The surrounding controller raises `tx_now` when the wire side takes the next pending frame, and `rx_push` when a received frame needs a page. The block reports the last transmit allocation, the number of free pages and the heads of the done and receive queues. It also keeps an interrupt status byte with a mask and an acknowledge path. A transmit allocation that finds the pool full is remembered and completes by itself on the next page release.

Top module: `pkt_page_alloc`

## Requirements
- R1: After a synchronous active-low reset, `alloc_result` reads 0x80, `free_count` equals PAGES, both queue heads read 0x80, `int_status` reads 0x04 and `int_mask` reads 0x00.
- R2: The allocate command (code 1 in bits 7:5, byte 0x20) first clears status bit 0x08. It then claims the lowest-numbered free page, sets `alloc_result` to that page and sets bit 0x08. When no page is free, `alloc_result` becomes 0x80, bit 0x08 stays clear and the request is held as pending.
- R3: While a transmit allocation is pending, any page release claims the lowest free page in the same cycle. The releases are command 5 (byte 0xA0, page = packet-number register), command 4 (byte 0x80) and an auto-release transmit. The claimed page is written to `alloc_result`, bit 0x08 is set and the pending state ends.
- R4: `free_count` equals PAGES minus the number of pages in use.
- R5: Command 6 (byte 0xC0) appends the packet-number register to the pending transmit queue, and is dropped when that queue is full. A `tx_now` strobe removes the pending head. If `auto_rel` is high it releases that page; otherwise it appends the page to the done queue.
- R6: An `rx_push` strobe claims the lowest free page, appends it to the receive queue and sets status bit 0x01. It is dropped when no page is free. Command 3 (byte 0x60) pops the receive queue. Command 4 first releases the receive head page, then pops. After either pop, bit 0x01 is set if entries remain and cleared otherwise.
- R7: Command 2 (byte 0x40) frees every page and empties all three queues. Command 7 (byte 0xE0) empties the two transmit queues only.
- R8: After every cycle's update, status bit 0x04 is set if the pending transmit queue is empty and bit 0x02 is set if the done queue is not empty. Both stay set until acknowledged.
- R9: An acknowledge write clears the status bits set in `ack_data & 0xD6`, so bits 0x08 and 0x01 cannot be cleared this way. If `ack_data` bit 1 is set, it also pops one entry from the done queue.
- R10: `irq` is high exactly when `int_status & int_mask` is non-zero. `mask_we` loads `int_mask` from `mask_data`.
- R11: `tx_done_head` and `rx_head` read 0x80 when their queue is empty and the head page number otherwise.
- R12: At most one event is taken per cycle, in the priority order command, acknowledge, `tx_now`, `rx_push`. Lower-priority events in the same cycle are ignored. Writes to the packet-number and mask registers are independent of this order. A command uses the packet-number value held before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte, operation in bits 7:5 |
| pnum_we | input | 1 | Packet-number register write strobe |
| pnum_data | input | 8 | Packet-number value |
| ack_we | input | 1 | Interrupt acknowledge write strobe |
| ack_data | input | 8 | Bits to acknowledge |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | Interrupt mask value |
| auto_rel | input | 1 | Release transmitted pages instead of queuing them as done |
| tx_now | input | 1 | Transmit the pending head page |
| rx_push | input | 1 | Claim a page for a received frame |
| alloc_result | output | 8 | Last transmit allocation, 0x80 on failure |
| free_count | output | $clog2(PAGES+1) | Number of free pages |
| tx_done_head | output | 8 | Head of the done queue, 0x80 when empty |
| rx_head | output | 8 | Head of the receive queue, 0x80 when empty |
| int_status | output | 8 | Interrupt status byte |
| int_mask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Interrupt request |

## Verification
Every event is registered on the edge that samples it. Its effect on `alloc_result`, `free_count`, both queue heads, `int_status` and `int_mask` is visible one cycle later. `irq` follows in that same cycle, since it is a gate on two registered bytes. The bench drives inputs on the falling edge and the reference model updates on the rising edge. All outputs are compared on the next falling edge, exactly one cycle after each stimulus. Directed checks at the corner cases are sampled at that same point.

// File: rtl/pkt_alloc_pkg.sv
// Shared command codes and status bit constants for the page allocator.
package pkt_alloc_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_TX_ALLOC   = 3'd1,
        OP_POOL_RESET = 3'd2,
        OP_RX_POP     = 3'd3,
        OP_RX_POP_REL = 3'd4,
        OP_RELEASE    = 3'd5,
        OP_TX_ENQ     = 3'd6,
        OP_TX_RESET   = 3'd7
    } page_op_e;

    localparam logic [7:0] ST_RCV   = 8'h01;
    localparam logic [7:0] ST_TX    = 8'h02;
    localparam logic [7:0] ST_TXE   = 8'h04;
    localparam logic [7:0] ST_ALLOC = 8'h08;
    localparam logic [7:0] ACK_MASK = 8'hD6;
    localparam logic [7:0] NO_PAGE  = 8'h80;

endpackage

// File: rtl/page_queue.sv
// Shift-register FIFO of page numbers.
// Assumes: clear wins over push/pop; pop of an empty queue is a no-op;
// a push is accepted only if room remains after this cycle's pop.
module page_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         empty_nxt
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [W-1:0]  slot_q [DEPTH];
    logic [W-1:0]  slot_d [DEPTH];
    logic [CW-1:0] cnt_q, cnt_pop, cnt_d;
    logic          do_push, do_pop;

    // Occupancy after this cycle's pop and push.
    always_comb begin
        do_pop  = pop && (cnt_q != '0);
        cnt_pop = do_pop ? cnt_q - 1'b1 : cnt_q;
        do_push = push && (cnt_pop < DEPTH_C);
        cnt_d   = clr ? '0 : cnt_pop + CW'(do_push);
    end

    // Next slot contents: shift on pop, write at the new tail on push.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (do_pop) begin
                slot_d[i] = (i + 1 < DEPTH) ? slot_q[(i + 1) % DEPTH] : '0;
            end else begin
                slot_d[i] = slot_q[i];
            end
            if (do_push && (cnt_pop == CW'(i))) begin
                slot_d[i] = push_val;
            end
        end
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Slot registers, one per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end
    end

    assign head      = slot_q[0];
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == DEPTH_C);
    assign empty_nxt = (cnt_d == '0);

endmodule

// File: rtl/page_pool.sv
// Bitmask of pages in use with a lowest-free-page finder.
// Assumes: a release is applied before the search, so a page freed this
// cycle can be claimed in the same cycle; clear wins over everything.
module page_pool #(
    parameter int PAGES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         rel_en,
    input  logic [$clog2(PAGES)-1:0]     rel_idx,
    input  logic                         take_en,
    output logic                         take_ok,
    output logic [$clog2(PAGES)-1:0]     take_idx,
    output logic [$clog2(PAGES+1)-1:0]   free_cnt
);
    localparam int PW = $clog2(PAGES);
    localparam int CW = $clog2(PAGES + 1);

    logic [PAGES-1:0] used_q, after_rel, grant_oh;

    // Apply this cycle's release to the in-use mask.
    always_comb begin
        after_rel = used_q;
        if (rel_en) after_rel[rel_idx] = 1'b0;
    end

    // Find the lowest-numbered free page after the release.
    always_comb begin
        take_ok  = 1'b0;
        take_idx = '0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (!after_rel[i]) begin
                take_ok  = 1'b1;
                take_idx = PW'(i);
            end
        end
        grant_oh = '0;
        if (take_en && take_ok) grant_oh[take_idx] = 1'b1;
    end

    // Count free pages in the registered mask.
    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < PAGES; i++) begin
            free_cnt = free_cnt + CW'(!used_q[i]);
        end
    end

    // In-use mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)   used_q <= '0;
        else if (clr) used_q <= '0;
        else          used_q <= after_rel | grant_oh;
    end

endmodule

// File: rtl/pkt_page_alloc.sv
// Packet page allocator: decodes the command byte, acknowledge, transmit
// and receive events (one per cycle, in that priority), drives the page
// pool and three page queues, and keeps interrupt status, mask, last
// allocation result and a pending-allocation flag.
// Assumes: PAGES is a power of two no larger than 128.
module pkt_page_alloc
    import pkt_alloc_pkg::*;
#(
    parameter int PAGES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_we,
    input  logic [7:0]                 cmd_data,
    input  logic                       pnum_we,
    input  logic [7:0]                 pnum_data,
    input  logic                       ack_we,
    input  logic [7:0]                 ack_data,
    input  logic                       mask_we,
    input  logic [7:0]                 mask_data,
    input  logic                       auto_rel,
    input  logic                       tx_now,
    input  logic                       rx_push,
    output logic [7:0]                 alloc_result,
    output logic [$clog2(PAGES+1)-1:0] free_count,
    output logic [7:0]                 tx_done_head,
    output logic [7:0]                 rx_head,
    output logic [7:0]                 int_status,
    output logic [7:0]                 int_mask,
    output logic                       irq
);
    localparam int PW = $clog2(PAGES);

    page_op_e    op;
    logic [7:0]  status_q, status_d, st_core, mask_q, result_q, result_d, pnum_q;
    logic        pend_q, pend_d, rx_pop_cmd;

    logic          pool_clr, rel_en, take_en, take_ok;
    logic [PW-1:0] rel_idx, take_idx;

    logic          txq_clr, txq_push, txq_pop, txq_empty, txq_full, txq_empty_nxt;
    logic [PW-1:0] txq_head;
    logic          dq_clr, dq_push, dq_pop, dq_empty, dq_full, dq_empty_nxt;
    logic [PW-1:0] dq_head;
    logic          rxq_clr, rxq_push, rxq_pop, rxq_empty, rxq_full, rxq_empty_nxt;
    logic [PW-1:0] rxq_head;

    assign op = page_op_e'(cmd_data[7:5]);

    page_pool #(.PAGES(PAGES)) u_pool (
        .clk(clk), .rst_n(rst_n), .clr(pool_clr),
        .rel_en(rel_en), .rel_idx(rel_idx), .take_en(take_en),
        .take_ok(take_ok), .take_idx(take_idx), .free_cnt(free_count)
    );

    page_queue #(.DEPTH(PAGES), .W(PW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(txq_clr), .push(txq_push),
        .push_val(pnum_q[PW-1:0]), .pop(txq_pop), .head(txq_head),
        .empty(txq_empty), .full(txq_full), .empty_nxt(txq_empty_nxt)
    );

    page_queue #(.DEPTH(PAGES), .W(PW)) u_doneq (
        .clk(clk), .rst_n(rst_n), .clr(dq_clr), .push(dq_push),
        .push_val(txq_head), .pop(dq_pop), .head(dq_head),
        .empty(dq_empty), .full(dq_full), .empty_nxt(dq_empty_nxt)
    );

    page_queue #(.DEPTH(PAGES), .W(PW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rxq_clr), .push(rxq_push),
        .push_val(take_idx), .pop(rxq_pop), .head(rxq_head),
        .empty(rxq_empty), .full(rxq_full), .empty_nxt(rxq_empty_nxt)
    );

    // Select which page, if any, is released this cycle.
    always_comb begin
        rel_en  = 1'b0;
        rel_idx = '0;
        if (cmd_we) begin
            if (op == OP_RX_POP_REL && !rxq_empty) begin
                rel_en  = 1'b1;
                rel_idx = rxq_head;
            end else if (op == OP_RELEASE) begin
                rel_en  = 1'b1;
                rel_idx = pnum_q[PW-1:0];
            end
        end else if (!ack_we && tx_now && !txq_empty && auto_rel) begin
            rel_en  = 1'b1;
            rel_idx = txq_head;
        end
    end

    // Decode the winning event into queue, pool and status actions.
    always_comb begin
        st_core    = status_q;
        result_d   = result_q;
        pend_d     = pend_q;
        take_en    = 1'b0;
        pool_clr   = 1'b0;
        rx_pop_cmd = 1'b0;
        txq_clr = 1'b0; txq_push = 1'b0; txq_pop = 1'b0;
        dq_clr  = 1'b0; dq_push  = 1'b0; dq_pop  = 1'b0;
        rxq_clr = 1'b0; rxq_push = 1'b0; rxq_pop = 1'b0;
        if (cmd_we) begin
            unique case (op)
                OP_TX_ALLOC: begin
                    st_core = st_core & ~ST_ALLOC;
                    take_en = 1'b1;
                    if (take_ok) begin
                        result_d = {{(8-PW){1'b0}}, take_idx};
                        st_core  = st_core | ST_ALLOC;
                        pend_d   = 1'b0;
                    end else begin
                        result_d = NO_PAGE;
                        pend_d   = 1'b1;
                    end
                end
                OP_POOL_RESET: begin
                    pool_clr = 1'b1;
                    txq_clr  = 1'b1;
                    dq_clr   = 1'b1;
                    rxq_clr  = 1'b1;
                end
                OP_RX_POP, OP_RX_POP_REL: begin
                    rxq_pop    = 1'b1;
                    rx_pop_cmd = 1'b1;
                end
                OP_TX_ENQ: txq_push = 1'b1;
                OP_TX_RESET: begin
                    txq_clr = 1'b1;
                    dq_clr  = 1'b1;
                end
                default: ;
            endcase
        end else if (ack_we) begin
            st_core = st_core & ~(ack_data & ACK_MASK);
            dq_pop  = ack_data[1];
        end else if (tx_now) begin
            txq_pop = 1'b1;
            dq_push = !txq_empty && !auto_rel;
        end else if (rx_push) begin
            take_en = !rxq_full;
            if (take_ok && !rxq_full) begin
                rxq_push = 1'b1;
                st_core  = st_core | ST_RCV;
            end
        end
        if (rel_en && pend_q) begin
            take_en  = 1'b1;
            result_d = {{(8-PW){1'b0}}, take_idx};
            st_core  = st_core | ST_ALLOC;
            pend_d   = 1'b0;
        end
    end

    // Fold in queue-derived status bits after the update.
    always_comb begin
        status_d = st_core;
        if (rx_pop_cmd)     status_d[0] = !rxq_empty_nxt;
        if (txq_empty_nxt)  status_d = status_d | ST_TXE;
        if (!dq_empty_nxt)  status_d = status_d | ST_TX;
    end

    // Status, result and pending-allocation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_TXE;
            result_q <= NO_PAGE;
            pend_q   <= 1'b0;
        end else begin
            status_q <= status_d;
            result_q <= result_d;
            pend_q   <= pend_d;
        end
    end

    // Software-written mask and packet-number registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pnum_q <= '0;
        end else begin
            if (mask_we) mask_q <= mask_data;
            if (pnum_we) pnum_q <= pnum_data;
        end
    end

    assign alloc_result = result_q;
    assign int_status   = status_q;
    assign int_mask     = mask_q;
    assign irq          = |(status_q & mask_q);
    assign tx_done_head = dq_empty  ? NO_PAGE : {{(8-PW){1'b0}}, dq_head};
    assign rx_head      = rxq_empty ? NO_PAGE : {{(8-PW){1'b0}}, rxq_head};

endmodule

// File: rtl/pkt_page_alloc_chk.sv
// Port-level property checker for pkt_page_alloc, attached by bind.
module pkt_page_alloc_chk #(
    parameter int PAGES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_we,
    input logic [7:0]                 cmd_data,
    input logic                       mask_we,
    input logic [7:0]                 mask_data,
    input logic [7:0]                 alloc_result,
    input logic [$clog2(PAGES+1)-1:0] free_count,
    input logic [7:0]                 tx_done_head,
    input logic [7:0]                 rx_head,
    input logic [7:0]                 int_status,
    input logic [7:0]                 int_mask
);
    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_count) <= PAGES); // R4

    AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_result == 8'h80) || (int'(alloc_result) < PAGES)); // R2

    AST_ALLOC_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[7:5] == 3'd1 && free_count == '0)
        |=> (alloc_result == 8'h80) && !int_status[3]); // R2

    AST_ALLOC_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[7:5] == 3'd1 && free_count != '0)
        |=> int_status[3] && (free_count == $past(free_count) - 1'b1)); // R4

    AST_RCV_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[7:5] == 3'd3)
        |=> (int_status[0] == (rx_head != 8'h80))); // R6

    AST_TX_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_head != 8'h80) |-> int_status[1]); // R8

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (int_mask == $past(mask_data))); // R10

endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.PAGES(PAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .mask_we(mask_we), .mask_data(mask_data), .alloc_result(alloc_result),
    .free_count(free_count), .tx_done_head(tx_done_head), .rx_head(rx_head),
    .int_status(int_status), .int_mask(int_mask)
);

// File: tb/pkt_page_alloc_tb.sv
// Bench: behavioural queue model compared on every falling edge, plus
// directed corner-case checks.
module pkt_page_alloc_tb;
    localparam int PAGES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 0, pnum_we = 0, ack_we = 0, mask_we = 0;
    logic [7:0] cmd_data = 0, pnum_data = 0, ack_data = 0, mask_data = 0;
    logic       auto_rel = 0, tx_now = 0, rx_push = 0;
    logic [7:0] alloc_result, tx_done_head, rx_head, int_status, int_mask;
    logic [2:0] free_count;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    pkt_page_alloc #(.PAGES(PAGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .pnum_we(pnum_we), .pnum_data(pnum_data), .ack_we(ack_we),
        .ack_data(ack_data), .mask_we(mask_we), .mask_data(mask_data),
        .auto_rel(auto_rel), .tx_now(tx_now), .rx_push(rx_push),
        .alloc_result(alloc_result), .free_count(free_count),
        .tx_done_head(tx_done_head), .rx_head(rx_head),
        .int_status(int_status), .int_mask(int_mask), .irq(irq)
    );

    // Reference model state.
    bit [PAGES-1:0] m_used;
    int             m_txq[$], m_done[$], m_rxq[$];
    bit [7:0]       m_st, m_mask, m_res, m_pnum;
    bit             m_pend;

    function automatic int lowest_free();
        for (int i = 0; i < PAGES; i++) if (!m_used[i]) return i;
        return -1;
    endfunction

    task automatic m_release(input int p);
        int f;
        m_used[p] = 1'b0;
        if (m_pend) begin
            f = lowest_free();
            m_used[f] = 1'b1;
            m_res  = 8'(f);
            m_st   = m_st | 8'h08;
            m_pend = 1'b0;
        end
    endtask

    always @(posedge clk) begin : model
        int f, p;
        if (!rst_n) begin
            m_used = '0; m_txq.delete(); m_done.delete(); m_rxq.delete();
            m_st = 8'h04; m_mask = 0; m_res = 8'h80; m_pnum = 0; m_pend = 0;
        end else begin
            if (cmd_we) begin
                case (cmd_data[7:5])
                    3'd1: begin
                        m_st = m_st & ~8'h08;
                        f = lowest_free();
                        if (f >= 0) begin
                            m_used[f] = 1'b1; m_res = 8'(f);
                            m_st = m_st | 8'h08; m_pend = 0;
                        end else begin
                            m_res = 8'h80; m_pend = 1;
                        end
                    end
                    3'd2: begin
                        m_used = '0; m_txq.delete(); m_done.delete(); m_rxq.delete();
                    end
                    3'd3: begin
                        if (m_rxq.size() != 0) void'(m_rxq.pop_front());
                        m_st[0] = (m_rxq.size() != 0);
                    end
                    3'd4: begin
                        if (m_rxq.size() != 0) begin
                            p = m_rxq.pop_front();
                            m_release(p);
                        end
                        m_st[0] = (m_rxq.size() != 0);
                    end
                    3'd5: m_release(int'(m_pnum[1:0]));
                    3'd6: if (m_txq.size() < PAGES) m_txq.push_back(int'(m_pnum[1:0]));
                    3'd7: begin m_txq.delete(); m_done.delete(); end
                    default: ;
                endcase
            end else if (ack_we) begin
                m_st = m_st & ~(ack_data & 8'hD6);
                if (ack_data[1] && m_done.size() != 0) void'(m_done.pop_front());
            end else if (tx_now) begin
                if (m_txq.size() != 0) begin
                    p = m_txq.pop_front();
                    if (auto_rel) m_release(p);
                    else if (m_done.size() < PAGES) m_done.push_back(p);
                end
            end else if (rx_push) begin
                f = lowest_free();
                if (f >= 0 && m_rxq.size() < PAGES) begin
                    m_used[f] = 1'b1; m_rxq.push_back(f); m_st = m_st | 8'h01;
                end
            end
            if (m_txq.size() == 0)  m_st = m_st | 8'h04;
            if (m_done.size() != 0) m_st = m_st | 8'h02;
            if (mask_we) m_mask = mask_data;
            if (pnum_we) m_pnum = pnum_data;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2/R3 alloc_result", alloc_result, m_res);
        check("R4 free_count", free_count, PAGES - $countones(m_used));
        check("R5/R11 tx_done_head", tx_done_head, m_done.size() != 0 ? m_done[0] : 8'h80);
        check("R6/R11 rx_head", rx_head, m_rxq.size() != 0 ? m_rxq[0] : 8'h80);
        check("R8/R9 int_status", int_status, m_st);
        check("R10 int_mask", int_mask, m_mask);
        check("R10 irq", irq, |(m_st & m_mask));
    endtask

    // One clock: inputs already set, sample on the following falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        cmd_we = 0; pnum_we = 0; ack_we = 0; mask_we = 0; tx_now = 0; rx_push = 0;
    endtask

    task automatic cmd(input logic [7:0] b);
        cmd_we = 1; cmd_data = b; cyc();
    endtask

    task automatic set_pnum(input logic [7:0] v);
        pnum_we = 1; pnum_data = v; cyc();
    endtask

    task automatic ack(input logic [7:0] v);
        ack_we = 1; ack_data = v; cyc();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1;
        // R1: reset values
        check("R1 result", alloc_result, 8'h80);
        check("R1 free", free_count, 4);
        check("R1 done head", tx_done_head, 8'h80);
        check("R1 rx head", rx_head, 8'h80);
        check("R1 status", int_status, 8'h04);
        check("R1 mask", int_mask, 8'h00);

        mask_we = 1; mask_data = 8'hFF; cyc();
        check("R10 irq from TX_EMPTY", irq, 1);

        // R2: lowest-first allocation, then exhaustion
        for (int i = 0; i < 4; i++) begin
            cmd(8'h20);
            check("R2 alloc page", alloc_result, i);
        end
        check("R4 pool empty", free_count, 0);
        cmd(8'h20);
        check("R2 alloc fail result", alloc_result, 8'h80);
        check("R2 alloc fail status", int_status, 8'h04);

        // R3: retry on release by packet number
        set_pnum(8'h02);
        cmd(8'hA0);
        check("R3 retry result", alloc_result, 2);
        check("R3 retry status", int_status, 8'h0C);

        // R5/R8/R9: transmit path and sticky bits
        set_pnum(8'h01); cmd(8'hC0);
        ack(8'h04);
        check("R9 ack clears TX_EMPTY", int_status, 8'h08);
        set_pnum(8'h03); cmd(8'hC0);
        tx_now = 1; cyc();
        check("R5 done head", tx_done_head, 1);
        check("R8 TX bit", int_status, 8'h0A);
        auto_rel = 1; tx_now = 1; cyc();
        check("R5 auto release free", free_count, 1);
        check("R8 TX_EMPTY forced", int_status, 8'h0E);
        ack(8'h02);
        check("R9 ack pops done", tx_done_head, 8'h80);
        check("R9 TX cleared", int_status, 8'h0C);
        ack(8'h09);
        check("R9 ALLOC/RCV not acked", int_status, 8'h0C);
        ack(8'h04);
        check("R8 TX_EMPTY re-forced", int_status, 8'h0C);

        // R12: acknowledge beats tx_now in the same cycle
        auto_rel = 0;
        set_pnum(8'h00); cmd(8'hC0);
        ack_we = 1; ack_data = 8'h00; tx_now = 1; cyc();
        check("R12 tx_now ignored", tx_done_head, 8'h80);
        tx_now = 1; cyc();
        check("R12 tx_now alone", tx_done_head, 0);
        // R12: command beats rx_push
        cmd_we = 1; cmd_data = 8'h00; rx_push = 1; cyc();
        check("R12 rx_push ignored", rx_head, 8'h80);

        // R7: full allocator reset
        cmd(8'h40);
        check("R7 pool freed", free_count, 4);
        check("R7 done emptied", tx_done_head, 8'h80);

        // R6: receive queue
        for (int i = 0; i < 3; i++) begin rx_push = 1; cyc(); end
        check("R6 rx head", rx_head, 0);
        cmd(8'h60);
        check("R6 pop head", rx_head, 1);
        check("R6 RCV kept", int_status[0], 1);
        cmd(8'h80);
        check("R6 pop release free", free_count, 2);
        cmd(8'h80);
        check("R6 empty head", rx_head, 8'h80);
        check("R6 RCV cleared", int_status[0], 0);
        for (int i = 0; i < 4; i++) begin rx_push = 1; cyc(); end
        check("R6 drop when full", rx_head, 1);
        check("R4 none free", free_count, 0);

        // R3: retry through pop-and-release
        cmd(8'h20);
        check("R3 pending fail", alloc_result, 8'h80);
        cmd(8'h80);
        check("R3 retry via rx release", alloc_result, 1);

        // R7: transmit-only reset keeps pages
        set_pnum(8'h01); cmd(8'hC0);
        cmd(8'hE0);
        check("R7 tx reset keeps pages", free_count, 0);
        check("R7 TX_EMPTY after tx reset", int_status[2], 1);

        // R3: retry through auto-release transmit
        cmd(8'h20);
        cmd(8'hC0);
        auto_rel = 1; tx_now = 1; cyc();
        check("R3 retry via auto release", alloc_result, 1);
        auto_rel = 0;

        // Mixed traffic compared against the model every cycle.
        for (int i = 0; i < 60; i++) begin
            case (i % 6)
                0: rx_push = 1;
                1: cmd_data = 8'h80;
                2: cmd_data = 8'h20;
                3: cmd_data = 8'hC0;
                4: tx_now = 1;
                default: ack_data = 8'hFF;
            endcase
            cmd_we = (i % 6 == 1) || (i % 6 == 2) || (i % 6 == 3);
            ack_we = (i % 6 == 5);
            pnum_we = 1; pnum_data = 8'(i % 4);
            auto_rel = (i % 12) > 5;
            cyc();
        end

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule